// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block is a 36-bit first-in first-out buffer. A producer writes on one clock and a consumer reads on another. The two clocks may be unrelated. Each side has its own synchronous active-high reset. The write side shows an input-ready flag and an active-low almost-full flag. The read side shows an output-ready flag, the head word, and an active-low almost-empty flag. Read and write pointers pass between the clock domains as gray code, through two-flop synchronisers.

The almost-full and almost-empty thresholds are fixed when the write-side reset is released. A two-bit select input is captured on the last write-clock edge at which reset is high. A non-zero code picks one of three preset thresholds, which applies to both flags. Code 00 selects a serial load instead: the first four accepted writes after reset are configuration words, not data.

The read side works in first-word-fall-through style. When a word is present, it is already on `rd_data` and `out_rdy` is high. Asserting `rd_en` for one read-clock edge takes that word.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: `in_rdy` is low while `wr_rst` is high. It stays low after the first write-clock edge with reset low and goes high after the second such edge.
- R2: The buffer holds at most 512 words, counting the word waiting on `rd_data`. `in_rdy` goes low on the write-clock edge that stores the 512th word. A write presented while `in_rdy` is low changes nothing and is never read out.
- R3: Words leave in the order they were written. `out_rdy` is high whenever a word is presented on `rd_data`. That word stays on `rd_data`, and `out_rdy` stays high, until a read-clock edge with `rd_en` high takes it. `out_rdy` falls only when that read leaves the buffer empty.
- R4: On the read clock, `alm_empty_n` is low whenever the stored word count, including the presented word, is less than or equal to the almost-empty threshold. It is low during reset.
- R5: On the write clock, `alm_full_n` is low whenever the free space (512 minus the stored count) is less than or equal to the almost-full threshold. When no reads take place, it is updated on the same edge that accepts the write. It is high during reset.
- R6: `ofs_sel` is sampled only on the last write-clock edge with `wr_rst` high. The codes 01, 10 and 11 set both thresholds to 8, 16 and 64. Later changes of `ofs_sel` have no effect.
- R7: With `ofs_sel` = 00 at release, the first four accepted writes are configuration words. Words 1 and 2 are consumed with no effect. Bits [9:0] of word 3 set the almost-empty threshold, and bits [9:0] of word 4 set the almost-full threshold. The fifth accepted write is the first data word.
- R8: Space freed by reads reaches the write side through the synchronised read pointer. After one word is read from a full buffer, `in_rdy` returns high within a few write-clock cycles.
- R9: A read request made while `out_rdy` is low has no effect. It neither removes a word nor changes the count seen by the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_en | input | 1 | Write request; taken when `in_rdy` is high |
| wr_data | input | 36 | Word to write (a configuration word during a serial load) |
| ofs_sel | input | 2 | Threshold select, sampled when reset is released |
| in_rdy | output | 1 | High when a write will be accepted |
| alm_full_n | output | 1 | Active-low almost-full flag (write clock) |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_en | input | 1 | Takes the presented word when `out_rdy` is high |
| rd_data | output | 36 | Word at the head of the buffer |
| out_rdy | output | 1 | High when `rd_data` holds a valid word |
| alm_empty_n | output | 1 | Active-low almost-empty flag (read clock) |

## Verification
Results in the write domain come one edge after the stimulus. `in_rdy` and `alm_full_n` are registered on the edge that accepts the write, so the bench checks them just after that edge when no reads are in progress. Results that cross domains pass through two synchroniser flops and one output register, so they come three read edges after the write edge: `out_rdy`, `rd_data`, `alm_empty_n`, and the return of `in_rdy` after a read. For these the bench waits a fixed settle window of eight edges in each domain before it samples. It checks release timing edge by edge, and it checks threshold boundaries one word below and at the threshold.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // threshold select codes captured at reset release
  typedef enum logic [1:0] {
    SEL_SERIAL = 2'b00,
    SEL_LOW    = 2'b01,
    SEL_MID    = 2'b10,
    SEL_HIGH   = 2'b11
  } ofs_sel_e;

  localparam int unsigned DEF_DATA_W  = 36;
  localparam int unsigned DEF_DEPTH   = 512;
  localparam int unsigned DEF_PRE_LOW = 8;
  localparam int unsigned DEF_PRE_MID = 16;
  localparam int unsigned DEF_PRE_HI  = 64;
  localparam int unsigned CFG_WORDS   = 4;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read with enable: maps onto a block RAM output register
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned PRE_LOW = 8,
  parameter int unsigned PRE_MID = 16,
  parameter int unsigned PRE_HI  = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        ofs_sel,
  input  logic [PTR_W-1:0]  rd_gray_s,
  output logic              in_rdy,
  output logic              alm_full_n,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [PTR_W-1:0]  wr_gray,
  output logic [PTR_W-1:0]  ae_ofs
);
  import dcf_pkg::*;

  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
  localparam int unsigned      CNT_W    = $clog2(CFG_WORDS + 1);
  localparam logic [CNT_W-1:0] CFG_END  = CNT_W'(CFG_WORDS);

  logic [PTR_W-1:0] wbin, wbin_nx, rbin_s, used_nx, free_nx, af_ofs;
  logic [CNT_W-1:0] cfg_cnt;
  logic             serial_mode, wake, accept, loading, data_we;

  // gray to binary for the synchronised consumed-read pointer
  always_comb begin
    for (int i = 0; i < int'(PTR_W); i++) rbin_s[i] = ^(rd_gray_s >> i);
  end

  assign accept    = wr_en && in_rdy;
  assign loading   = serial_mode && (cfg_cnt != CFG_END);
  assign data_we   = accept && !loading;
  assign wbin_nx   = wbin + PTR_W'(data_we);
  assign used_nx   = wbin_nx - rbin_s;
  assign free_nx   = FULL_CNT - used_nx;
  assign mem_we    = data_we;
  assign mem_waddr = wbin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wr_gray     <= '0;
      wake        <= 1'b0;
      in_rdy      <= 1'b0;
      alm_full_n  <= 1'b1;
      cfg_cnt     <= '0;
      serial_mode <= (ofs_sel == SEL_SERIAL);
      case (ofs_sel)
        SEL_LOW:  begin ae_ofs <= PTR_W'(PRE_LOW); af_ofs <= PTR_W'(PRE_LOW); end
        SEL_MID:  begin ae_ofs <= PTR_W'(PRE_MID); af_ofs <= PTR_W'(PRE_MID); end
        SEL_HIGH: begin ae_ofs <= PTR_W'(PRE_HI);  af_ofs <= PTR_W'(PRE_HI);  end
        default:  begin ae_ofs <= '0;              af_ofs <= '0;              end
      endcase
    end else begin
      wake       <= 1'b1;
      wbin       <= wbin_nx;
      wr_gray    <= wbin_nx ^ (wbin_nx >> 1);
      in_rdy     <= wake && (used_nx != FULL_CNT);
      alm_full_n <= !(free_nx <= af_ofs);
      if (accept && loading) begin
        cfg_cnt <= cfg_cnt + CNT_W'(1);
        // slots 0 and 1 belong to no threshold of this buffer
        if (cfg_cnt == CNT_W'(2)) ae_ofs <= wr_data[PTR_W-1:0];
        if (cfg_cnt == CNT_W'(3)) af_ofs <= wr_data[PTR_W-1:0];
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_rdy) |=> $stable(wbin));

  // R1
  wake_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || $past(rst, 2)) |-> !in_rdy);

  // R7
  cfg_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_rdy && loading) |=> $stable(wbin));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  wr_gray_s,
  input  logic [PTR_W-1:0]  ae_ofs,
  input  logic [DATA_W-1:0] mem_q,
  output logic              out_rdy,
  output logic              alm_empty_n,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [PTR_W-1:0]  rd_gray
);
  logic [PTR_W-1:0] wbin_s, fbin, cbin, fbin_nx, cbin_nx, cnt_nx;
  logic             consume, fetch, avail, out_nx;

  always_comb begin
    for (int i = 0; i < int'(PTR_W); i++) wbin_s[i] = ^(wr_gray_s >> i);
  end

  assign avail     = (wbin_s != fbin);
  assign consume   = rd_en && out_rdy;
  assign fetch     = avail && (!out_rdy || consume);
  assign fbin_nx   = fbin + PTR_W'(fetch);
  assign cbin_nx   = cbin + PTR_W'(consume);
  assign out_nx    = fetch || (out_rdy && !consume);
  assign cnt_nx    = wbin_s - cbin_nx;
  assign mem_re    = fetch;
  assign mem_raddr = fbin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fbin        <= '0;
      cbin        <= '0;
      rd_gray     <= '0;
      out_rdy     <= 1'b0;
      alm_empty_n <= 1'b0;
    end else begin
      fbin        <= fbin_nx;
      cbin        <= cbin_nx;
      rd_gray     <= cbin_nx ^ (cbin_nx >> 1);
      out_rdy     <= out_nx;
      alm_empty_n <= !(cnt_nx <= ae_ofs);
    end
  end

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !out_rdy) |=> $stable(cbin));

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_rdy && !rd_en) |=> (out_rdy && $stable(mem_q)));

  // R3
  drop_by_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_rdy) |-> $past(rd_en));
endmodule

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo #(
  parameter int unsigned DATA_W  = dcf_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH   = dcf_pkg::DEF_DEPTH,
  parameter int unsigned PRE_LOW = dcf_pkg::DEF_PRE_LOW,
  parameter int unsigned PRE_MID = dcf_pkg::DEF_PRE_MID,
  parameter int unsigned PRE_HI  = dcf_pkg::DEF_PRE_HI
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        ofs_sel,
  output logic              in_rdy,
  output logic              alm_full_n,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_rdy,
  output logic              alm_empty_n
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned PTR_W  = ADDR_W + 1;

  logic [PTR_W-1:0]  wr_gray, wr_gray_s, rd_gray, rd_gray_s, ae_ofs;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              mem_we, mem_re;

  dcf_wr_ctl #(
    .DATA_W(DATA_W), .DEPTH(DEPTH),
    .PRE_LOW(PRE_LOW), .PRE_MID(PRE_MID), .PRE_HI(PRE_HI)
  ) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .ofs_sel(ofs_sel), .rd_gray_s(rd_gray_s), .in_rdy(in_rdy),
    .alm_full_n(alm_full_n), .mem_we(mem_we), .mem_waddr(waddr),
    .wr_gray(wr_gray), .ae_ofs(ae_ofs)
  );

  dcf_sync #(.WIDTH(PTR_W)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_s)
  );

  dcf_sync #(.WIDTH(PTR_W)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_s)
  );

  dcf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(mem_re), .raddr(raddr), .rdata(rd_data)
  );

  // ae_ofs is held static once data can flow: while it changes, the count is zero
  dcf_rd_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wr_gray_s(wr_gray_s),
    .ae_ofs(ae_ofs), .mem_q(rd_data), .out_rdy(out_rdy),
    .alm_empty_n(alm_empty_n), .mem_re(mem_re), .mem_raddr(raddr),
    .rd_gray(rd_gray)
  );
endmodule

// File: tb/dual_clk_flag_fifo_tb.sv
module dual_clk_flag_fifo_tb_top;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;

  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst = 1'b1, rd_rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [1:0]  ofs_sel = 2'b01;
  logic        in_rdy, alm_full_n, out_rdy, alm_empty_n;
  logic [35:0] rd_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(WR_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RD_PERIOD / 2) rd_clk = ~rd_clk;

  dual_clk_flag_fifo dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .ofs_sel(ofs_sel), .in_rdy(in_rdy), .alm_full_n(alm_full_n),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .out_rdy(out_rdy), .alm_empty_n(alm_empty_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] pat(input int i, input int salt);
    return {4'(i + salt), (32'(i) * 32'h9E3779B1) ^ 32'(salt)};
  endfunction

  task automatic hold_reset(input logic [1:0] sel);
    wr_en = 1'b0; rd_en = 1'b0; wr_rst = 1'b1; rd_rst = 1'b1; ofs_sel = sel;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
  endtask

  // sel_last is what the final reset edge sees; ofs_sel is scrambled afterwards
  task automatic release_reset(input logic [1:0] sel_last);
    @(negedge rd_clk) rd_rst = 1'b0;
    @(negedge wr_clk) ofs_sel = sel_last;
    @(negedge wr_clk) begin wr_rst = 1'b0; ofs_sel = ~sel_last; end
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
    @(posedge rd_clk); #1;
  endtask

  task automatic write_word(input logic [35:0] d);
    @(negedge wr_clk) begin wr_en = 1'b1; wr_data = d; end
    @(posedge wr_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic read_word(output logic [35:0] d);
    int waited = 0;
    @(negedge rd_clk);
    while (!out_rdy && waited < 50) begin @(negedge rd_clk); waited++; end
    d = rd_data;
    rd_en = 1'b1;
    @(posedge rd_clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic test_reset();
    hold_reset(2'b01);
    #1;
    chk("R1", "in_rdy in reset", 36'(in_rdy), 36'd0);
    chk("R3", "out_rdy in reset", 36'(out_rdy), 36'd0);
    chk("R4", "alm_empty_n in reset", 36'(alm_empty_n), 36'd0);
    chk("R5", "alm_full_n in reset", 36'(alm_full_n), 36'd1);
    release_reset(2'b01);
    @(posedge wr_clk); #1;
    chk("R1", "in_rdy after first edge", 36'(in_rdy), 36'd0);
    @(posedge wr_clk); #1;
    chk("R1", "in_rdy after second edge", 36'(in_rdy), 36'd1);
  endtask

  task automatic test_order();
    logic [35:0] d, held;
    int errs = 0;
    hold_reset(2'b01); release_reset(2'b01); settle();
    for (int i = 0; i < 8; i++) write_word(pat(i, 3));
    settle();
    chk("R4", "alm_empty_n at count 8", 36'(alm_empty_n), 36'd0);
    write_word(pat(8, 3));
    settle();
    chk("R4", "alm_empty_n at count 9", 36'(alm_empty_n), 36'd1);
    chk("R3", "out_rdy with data", 36'(out_rdy), 36'd1);
    held = rd_data;
    repeat (3) @(posedge rd_clk); #1;
    chk("R3", "head held without read", rd_data, held);
    chk("R3", "out_rdy held without read", 36'(out_rdy), 36'd1);
    for (int i = 0; i < 9; i++) begin
      read_word(d);
      if (d !== pat(i, 3)) errs++;
    end
    chk("R3", "order mismatches", 36'(errs), 36'd0);
    settle();
    chk("R3", "out_rdy after drain", 36'(out_rdy), 36'd0);
    // R9: read requests on an empty buffer
    @(negedge rd_clk) rd_en = 1'b1;
    repeat (3) @(posedge rd_clk);
    #1 rd_en = 1'b0;
    settle();
    chk("R9", "alm_empty_n after empty reads", 36'(alm_empty_n), 36'd0);
    write_word(pat(99, 3));
    settle();
    read_word(d);
    chk("R9", "word after empty reads", d, pat(99, 3));
    settle();
    chk("R9", "out_rdy after single word", 36'(out_rdy), 36'd0);
  endtask

  task automatic test_full();
    logic [35:0] d;
    int errs = 0;
    hold_reset(2'b01); release_reset(2'b01); settle();
    for (int i = 0; i < 512; i++) begin
      write_word(pat(i, 7));
      if (i == 502) chk("R5", "alm_full_n at free 9", 36'(alm_full_n), 36'd1);
      if (i == 503) chk("R5", "alm_full_n at free 8", 36'(alm_full_n), 36'd0);
      if (i == 510) chk("R2", "in_rdy at 511 words", 36'(in_rdy), 36'd1);
      if (i == 511) chk("R2", "in_rdy at 512 words", 36'(in_rdy), 36'd0);
    end
    write_word(36'hF_FFFF_FFFF);
    chk("R2", "in_rdy after blocked write", 36'(in_rdy), 36'd0);
    read_word(d);
    if (d !== pat(0, 7)) errs++;
    settle();
    chk("R8", "in_rdy after one read", 36'(in_rdy), 36'd1);
    for (int i = 1; i < 512; i++) begin
      read_word(d);
      if (d !== pat(i, 7)) errs++;
    end
    chk("R2", "full drain mismatches", 36'(errs), 36'd0);
    settle();
    chk("R2", "blocked word absent", 36'(out_rdy), 36'd0);
  endtask

  task automatic test_presets();
    // R6: held at 11 but 10 on the final reset edge -> threshold 16
    hold_reset(2'b11); release_reset(2'b10); settle();
    for (int i = 0; i < 16; i++) write_word(pat(i, 1));
    settle();
    chk("R6", "code 10 alm_empty_n at 16", 36'(alm_empty_n), 36'd0);
    write_word(pat(16, 1));
    settle();
    chk("R6", "code 10 alm_empty_n at 17", 36'(alm_empty_n), 36'd1);
    hold_reset(2'b01); release_reset(2'b11); settle();
    for (int i = 0; i < 64; i++) write_word(pat(i, 2));
    settle();
    chk("R6", "code 11 alm_empty_n at 64", 36'(alm_empty_n), 36'd0);
    write_word(pat(64, 2));
    settle();
    chk("R6", "code 11 alm_empty_n at 65", 36'(alm_empty_n), 36'd1);
    for (int i = 65; i < 448; i++) begin
      write_word(pat(i, 2));
      if (i == 446) chk("R6", "code 11 alm_full_n at 447", 36'(alm_full_n), 36'd1);
      if (i == 447) chk("R6", "code 11 alm_full_n at 448", 36'(alm_full_n), 36'd0);
    end
  endtask

  task automatic test_serial();
    logic [35:0] d;
    hold_reset(2'b00); release_reset(2'b00); settle();
    write_word(36'h0_0000_01FF);   // slot 1, no effect
    write_word(36'h0_0000_03FF);   // slot 2, no effect
    write_word(36'h0_0000_0003);   // almost-empty threshold 3
    write_word(36'h0_0000_0005);   // almost-full threshold 5
    settle();
    chk("R7", "config words not stored", 36'(out_rdy), 36'd0);
    for (int i = 0; i < 3; i++) write_word(pat(i, 5));
    settle();
    chk("R7", "alm_empty_n at count 3", 36'(alm_empty_n), 36'd0);
    write_word(pat(3, 5));
    settle();
    chk("R7", "alm_empty_n at count 4", 36'(alm_empty_n), 36'd1);
    read_word(d);
    chk("R7", "fifth write is first data", d, pat(0, 5));
    settle();
    for (int i = 4; i < 507; i++) write_word(pat(i, 5));
    chk("R7", "alm_full_n at 506 words", 36'(alm_full_n), 36'd1);
    write_word(pat(507, 5));
    chk("R7", "alm_full_n at 507 words", 36'(alm_full_n), 36'd0);
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_order();
    test_full();
    test_presets();
    test_serial();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule